// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source layer of an interrupt network. It keeps a small table of interrupt sources. Each entry holds a target server number, a priority, a saved priority, a 4-bit status field, and a per-source type. The type is supplied on an input: level-sensitive or message. The block watches the raw source inputs and accepts configuration writes. It also accepts reject, end-of-interrupt (EOI) and resend operations from the presenter side. From these it decides when a source must be presented to a server.

Sources are addressed by a global number, which is the table index plus a fixed base of 0x1000. Any event that decides a source must be presented sets a pending bit for that source. A fixed-priority arbiter drains the pending bits, one delivery per cycle, carrying the server, global number and priority. A combinational lookup port returns any entry's contents, which is how the rest of the chip reads the table state.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every entry has server 0, priority 0xFF, saved priority 0xFF and status 0, and no delivery is issued.
- R2: A global number is accepted only when it lies in [0x1000, 0x1000 + NUM_SRC). Configuration writes, rejects and EOIs to other numbers change no entry, and every delivery number lies in that window.
- R3: A configuration write stores server, priority and saved priority into the addressed entry.
- R4: For a level source, a rising input sets status bit 0 (asserted, 0x1) and a falling input clears it.
- R5: A level source is presented when its priority is not 0xFF, asserted is set and status bit 1 (sent, 0x2) is clear. Presenting it sets sent.
- R6: A rising input on a message source delivers it when its priority is not 0xFF. Otherwise the rising input sets status bit 3 (masked-pending, 0x8) and delivers nothing.
- R7: On a configuration write, a message source with masked-pending set and a new priority other than 0xFF clears masked-pending and is delivered. A level source applies the R5 rule with the new priority.
- R8: A reject (pres_op_i = 1) sets status bit 2 (rejected, 0x4) and clears sent.
- R9: A resend (pres_op_i = 3) visits every entry. Level sources apply the R5 rule. A message source with rejected set clears it and is delivered if its priority is not 0xFF.
- R10: An EOI (pres_op_i = 2) to a level source clears sent and then applies the R5 rule. An EOI to a message source changes nothing.
- R11: At most one delivery is issued per cycle, pending sources drain lowest index first, and the delivered number is 0x1000 plus the index. A delivery appears on the second clock edge after the triggering event.
- R12: The lookup port returns the addressed entry's server, priority, saved priority and status combinationally, with a hit flag for valid numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lvl_type_i | input | NUM_SRC | Per-source type, 1 = level, 0 = message |
| src_i | input | NUM_SRC | Raw source inputs |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_num_i | input | NUM_W | Global number written |
| cfg_srv_i | input | SRV_W | Server to store |
| cfg_prio_i | input | PRIO_W | Priority to store |
| cfg_sprio_i | input | PRIO_W | Saved priority to store |
| pres_op_i | input | 2 | 0 none, 1 reject, 2 EOI, 3 resend |
| pres_num_i | input | NUM_W | Global number for reject and EOI |
| lkp_num_i | input | NUM_W | Global number to look up |
| lkp_hit_o | output | 1 | Lookup number is valid |
| lkp_srv_o | output | SRV_W | Looked-up server |
| lkp_prio_o | output | PRIO_W | Looked-up priority |
| lkp_sprio_o | output | PRIO_W | Looked-up saved priority |
| lkp_stat_o | output | 4 | Looked-up status bits |
| dlv_valid_o | output | 1 | Delivery valid |
| dlv_srv_o | output | SRV_W | Delivery target server |
| dlv_num_o | output | NUM_W | Delivery global number |
| dlv_prio_o | output | PRIO_W | Delivery priority |

## Verification
The assertions rely on three properties of the inputs:
- The source type of each entry never changes while the block is running.
- Reject, EOI and resend are mutually exclusive because they share one operation field.
- A message source marks each message with a rising edge and returns low before the next one.

The bench ties the type vector to a constant and drives message inputs as single-cycle pulses. It issues one presenter operation per cycle and lets the pending bits drain before it inspects state through the lookup port.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int ST_W        = 4;
  localparam int ST_ASSERTED = 0;
  localparam int ST_SENT     = 1;
  localparam int ST_REJECTED = 2;
  localparam int ST_MPEND    = 3;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_REJECT = 2'd1,
    OP_EOI    = 2'd2,
    OP_RESEND = 2'd3
  } pres_op_e;

  typedef struct packed {
    logic            fire;
    logic [ST_W-1:0] st;
  } step_t;

  // level re-presentation rule
  function automatic step_t lvl_retry(input logic [ST_W-1:0] st, input logic masked);
    step_t r;
    r.st   = st;
    r.fire = 1'b0;
    if (!masked && st[ST_ASSERTED] && !st[ST_SENT]) begin
      r.st[ST_SENT] = 1'b1;
      r.fire        = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_src_dec.sv
module irq_src_dec #(
  parameter int          NUM_SRC = 8,
  parameter int          NUM_W   = 20,
  parameter int unsigned BASE    = 32'h1000
) (
  input  logic [NUM_W-1:0]   num_i,
  output logic [NUM_SRC-1:0] sel_o
);

  logic [NUM_W-1:0] off;

  assign off = num_i - NUM_W'(BASE);

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      sel_o[k] = (off == NUM_W'(k));
    end
  end

endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  assign grant_o = req_i & (~req_i + 1'b1);
  assign any_o   = |req_i;

  always_comb begin
    idx_o = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              src_i,
  input  logic              cfg_we_i,
  input  logic [SRV_W-1:0]  cfg_srv_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_sprio_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              resend_i,
  input  logic              grant_i,
  output logic              fire_o,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0] sprio_o,
  output logic [ST_W-1:0]   stat_o
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic              src_q, fire_q, fire_new;
  logic [ST_W-1:0]   stat_q, stat_d;
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic [PRIO_W-1:0] prio_q, prio_d, sprio_q, sprio_d;
  logic              rise, fall;

  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  // events applied in order: input edge, reject, eoi, config, resend
  always_comb begin
    step_t           r;
    logic [ST_W-1:0] st;
    logic            hit;
    r       = '0;
    st      = stat_q;
    hit     = 1'b0;
    srv_d   = srv_q;
    prio_d  = prio_q;
    sprio_d = sprio_q;

    if (lvl_i) begin
      if (rise) begin
        st[ST_ASSERTED] = 1'b1;
        r   = lvl_retry(st, prio_q == MASKED);
        st  = r.st;
        hit = hit | r.fire;
      end
      if (fall) st[ST_ASSERTED] = 1'b0;
    end else if (rise) begin
      if (prio_q == MASKED) st[ST_MPEND] = 1'b1;
      else                  hit = 1'b1;
    end

    if (rej_i) begin
      st[ST_REJECTED] = 1'b1;
      st[ST_SENT]     = 1'b0;
    end

    if (eoi_i && lvl_i) begin
      st[ST_SENT] = 1'b0;
      r   = lvl_retry(st, prio_q == MASKED);
      st  = r.st;
      hit = hit | r.fire;
    end

    if (cfg_we_i) begin
      srv_d   = cfg_srv_i;
      prio_d  = cfg_prio_i;
      sprio_d = cfg_sprio_i;
      if (lvl_i) begin
        r   = lvl_retry(st, cfg_prio_i == MASKED);
        st  = r.st;
        hit = hit | r.fire;
      end else if (st[ST_MPEND] && cfg_prio_i != MASKED) begin
        st[ST_MPEND] = 1'b0;
        hit          = 1'b1;
      end
    end

    if (resend_i) begin
      if (lvl_i) begin
        r   = lvl_retry(st, prio_d == MASKED);
        st  = r.st;
        hit = hit | r.fire;
      end else if (st[ST_REJECTED]) begin
        st[ST_REJECTED] = 1'b0;
        if (prio_d != MASKED) hit = 1'b1;
      end
    end

    stat_d   = st;
    fire_new = hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      fire_q  <= 1'b0;
      stat_q  <= '0;
      srv_q   <= '0;
      prio_q  <= MASKED;
      sprio_q <= MASKED;
    end else begin
      src_q   <= src_i;
      fire_q  <= (fire_q & ~grant_i) | fire_new;
      stat_q  <= stat_d;
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      sprio_q <= sprio_d;
    end
  end

  assign fire_o  = fire_q;
  assign srv_o   = srv_q;
  assign prio_o  = prio_q;
  assign sprio_o = sprio_q;
  assign stat_o  = stat_q;

  p_rise_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && rise) |=> stat_q[ST_ASSERTED]);

  p_fall_deasserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && fall) |=> !stat_q[ST_ASSERTED]);

  p_masked_msg_pends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && rise && prio_q == MASKED && !cfg_we_i) |=> stat_q[ST_MPEND]);

  p_reject_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_i && !cfg_we_i) |=> (stat_q[ST_REJECTED] && !stat_q[ST_SENT]));

  p_eoi_msg_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && eoi_i && !cfg_we_i && !rise) |=> $stable(stat_q));

  p_pending_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_q && !grant_i) |=> fire_q);

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int          NUM_SRC = 8,
  parameter int          SRV_W   = 8,
  parameter int          PRIO_W  = 8,
  parameter int          NUM_W   = 20,
  parameter int unsigned BASE    = 32'h1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lvl_type_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we_i,
  input  logic [NUM_W-1:0]   cfg_num_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic [PRIO_W-1:0]  cfg_sprio_i,
  input  logic [1:0]         pres_op_i,
  input  logic [NUM_W-1:0]   pres_num_i,
  input  logic [NUM_W-1:0]   lkp_num_i,
  output logic               lkp_hit_o,
  output logic [SRV_W-1:0]   lkp_srv_o,
  output logic [PRIO_W-1:0]  lkp_prio_o,
  output logic [PRIO_W-1:0]  lkp_sprio_o,
  output logic [ST_W-1:0]    lkp_stat_o,
  output logic               dlv_valid_o,
  output logic [SRV_W-1:0]   dlv_srv_o,
  output logic [NUM_W-1:0]   dlv_num_o,
  output logic [PRIO_W-1:0]  dlv_prio_o
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  pres_op_e           op;
  logic [NUM_SRC-1:0] cfg_sel, pres_sel, lkp_sel;
  logic [NUM_SRC-1:0] fire, grant;
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_any;
  logic [SRV_W-1:0]   srv_a   [NUM_SRC];
  logic [PRIO_W-1:0]  prio_a  [NUM_SRC];
  logic [PRIO_W-1:0]  sprio_a [NUM_SRC];
  logic [ST_W-1:0]    stat_a  [NUM_SRC];

  assign op = pres_op_e'(pres_op_i);

  irq_src_dec #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_cfg_dec (
    .num_i(cfg_num_i), .sel_o(cfg_sel));
  irq_src_dec #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_pres_dec (
    .num_i(pres_num_i), .sel_o(pres_sel));
  irq_src_dec #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_lkp_dec (
    .num_i(lkp_num_i), .sel_o(lkp_sel));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    irq_src_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lvl_i       (lvl_type_i[g]),
      .src_i       (src_i[g]),
      .cfg_we_i    (cfg_we_i && cfg_sel[g]),
      .cfg_srv_i   (cfg_srv_i),
      .cfg_prio_i  (cfg_prio_i),
      .cfg_sprio_i (cfg_sprio_i),
      .rej_i       (op == OP_REJECT && pres_sel[g]),
      .eoi_i       (op == OP_EOI && pres_sel[g]),
      .resend_i    (op == OP_RESEND),
      .grant_i     (grant[g]),
      .fire_o      (fire[g]),
      .srv_o       (srv_a[g]),
      .prio_o      (prio_a[g]),
      .sprio_o     (sprio_a[g]),
      .stat_o      (stat_a[g])
    );
  end

  irq_src_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i   (fire),
    .grant_o (grant),
    .idx_o   (arb_idx),
    .any_o   (arb_any)
  );

  always_comb begin
    lkp_srv_o   = '0;
    lkp_prio_o  = '0;
    lkp_sprio_o = '0;
    lkp_stat_o  = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (lkp_sel[k]) begin
        lkp_srv_o   = srv_a[k];
        lkp_prio_o  = prio_a[k];
        lkp_sprio_o = sprio_a[k];
        lkp_stat_o  = stat_a[k];
      end
    end
  end
  assign lkp_hit_o = |lkp_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_valid_o <= 1'b0;
      dlv_srv_o   <= '0;
      dlv_num_o   <= '0;
      dlv_prio_o  <= '0;
    end else begin
      dlv_valid_o <= arb_any;
      if (arb_any) begin
        dlv_srv_o  <= srv_a[arb_idx];
        dlv_num_o  <= NUM_W'(BASE) + NUM_W'(arb_idx);
        dlv_prio_o <= prio_a[arb_idx];
      end
    end
  end

  p_pending_drains_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire) |=> dlv_valid_o);

  p_lowest_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_any |-> (((fire & grant) != '0) && (((grant - 1'b1) & fire) == '0)));

  p_dlv_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_num_o >= NUM_W'(BASE) && dlv_num_o < NUM_W'(BASE + NUM_SRC)));

endmodule

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;

  localparam int          N    = 8;
  localparam int unsigned BASE = 32'h1000;
  localparam logic [7:0]  LVL  = 8'h0F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        cfg_we = 1'b0;
  logic [19:0] cfg_num = '0, pres_num = '0, lkp_num = '0;
  logic [7:0]  cfg_srv = '0, cfg_prio = '0, cfg_sprio = '0;
  logic [1:0]  pres_op = 2'd0;
  logic        lkp_hit, dlv_valid;
  logic [7:0]  lkp_srv, lkp_prio, lkp_sprio, dlv_srv, dlv_prio;
  logic [3:0]  lkp_stat;
  logic [19:0] dlv_num;

  int vec = 0, bad = 0;
  logic [7:0] cur_srv [N];
  logic [7:0] cur_prio[N];
  logic [19:0] q_num[$];
  logic [7:0]  q_srv[$];
  logic [7:0]  q_prio[$];

  always #5 clk = ~clk;

  irq_src_ctrl u_irq_src_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lvl_type_i(LVL), .src_i(src),
    .cfg_we_i(cfg_we), .cfg_num_i(cfg_num), .cfg_srv_i(cfg_srv),
    .cfg_prio_i(cfg_prio), .cfg_sprio_i(cfg_sprio),
    .pres_op_i(pres_op), .pres_num_i(pres_num), .lkp_num_i(lkp_num),
    .lkp_hit_o(lkp_hit), .lkp_srv_o(lkp_srv), .lkp_prio_o(lkp_prio),
    .lkp_sprio_o(lkp_sprio), .lkp_stat_o(lkp_stat),
    .dlv_valid_o(dlv_valid), .dlv_srv_o(dlv_srv), .dlv_num_o(dlv_num),
    .dlv_prio_o(dlv_prio));

  always @(posedge clk) begin
    #2;
    if (rst_n && dlv_valid) begin
      q_num.push_back(dlv_num);
      q_srv.push_back(dlv_srv);
      q_prio.push_back(dlv_prio);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cfg(input int i, input logic [7:0] s, input logic [7:0] p, input logic [7:0] sp);
    cfg_we = 1'b1; cfg_num = 20'(BASE + i); cfg_srv = s; cfg_prio = p; cfg_sprio = sp;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic op(input logic [1:0] code, input logic [19:0] num);
    pres_op = code; pres_num = num;
    step(1);
    pres_op = 2'd0;
  endtask

  task automatic look_stat(input string tag, input int i, input logic [3:0] exp);
    lkp_num = 20'(BASE + i);
    #1;
    chk(tag, 32'(lkp_stat), 32'(exp));
  endtask

  task automatic exp_dlv(input string tag, input int i);
    if (q_num.size() == 0) begin
      chk({tag, " delivery count"}, 0, 1);
    end else begin
      chk({tag, " dlv num"}, 32'(q_num.pop_front()), 32'(BASE + i));
      chk({tag, " dlv srv"}, 32'(q_srv.pop_front()), 32'(cur_srv[i]));
      chk({tag, " dlv prio"}, 32'(q_prio.pop_front()), 32'(cur_prio[i]));
    end
  endtask

  task automatic exp_none(input string tag);
    chk({tag, " no extra delivery"}, 32'(q_num.size()), 0);
    q_num.delete(); q_srv.delete(); q_prio.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    chk("R1 no delivery", 32'(dlv_valid), 0);
    for (int i = 0; i < N; i++) begin
      lkp_num = 20'(BASE + i);
      #1;
      chk("R1 srv", 32'(lkp_srv), 0);
      chk("R1 prio", 32'(lkp_prio), 32'hFF);
      chk("R1 sprio", 32'(lkp_sprio), 32'hFF);
      chk("R1 stat", 32'(lkp_stat), 0);
      chk("R12 hit", 32'(lkp_hit), 1);
    end
    lkp_num = 20'(BASE - 1); #1; chk("R2 below window", 32'(lkp_hit), 0);
    lkp_num = 20'(BASE + N); #1; chk("R2 above window", 32'(lkp_hit), 0);

    // R3 config sweep
    for (int i = 0; i < N; i++) begin
      cur_srv[i]  = 8'(i * 3 + 1);
      cur_prio[i] = 8'(8'h20 + i * 4);
      cfg(i, cur_srv[i], cur_prio[i], 8'(8'h80 + i));
    end
    for (int i = 0; i < N; i++) begin
      lkp_num = 20'(BASE + i);
      #1;
      chk("R3 srv", 32'(lkp_srv), 32'(cur_srv[i]));
      chk("R3 prio", 32'(lkp_prio), 32'(cur_prio[i]));
      chk("R3 sprio", 32'(lkp_sprio), 32'(8'h80 + i));
    end
    cfg(N, 8'h55, 8'h01, 8'h02);
    cfg(-1, 8'h55, 8'h01, 8'h02);
    step(4);
    for (int i = 0; i < N; i++) begin
      lkp_num = 20'(BASE + i);
      #1;
      chk("R2 cfg outside ignored srv", 32'(lkp_srv), 32'(cur_srv[i]));
      chk("R2 cfg outside ignored prio", 32'(lkp_prio), 32'(cur_prio[i]));
    end
    exp_none("R7 cfg without pending");

    // level sources
    for (int i = 0; i < 4; i++) begin
      src[i] = 1'b1; step(4);
      exp_dlv("R5 level rise", i); exp_none("R5");
      look_stat("R4 R5 asserted+sent", i, 4'h3);
      op(2'd1, 20'(BASE + i)); step(4);
      exp_none("R8 reject level"); look_stat("R8 reject level", i, 4'h5);
      op(2'd3, '0); step(4);
      exp_dlv("R9 resend level", i); exp_none("R9"); look_stat("R9 level", i, 4'h7);
      op(2'd2, 20'(BASE + i)); step(4);
      exp_dlv("R10 eoi asserted", i); exp_none("R10"); look_stat("R10 eoi asserted", i, 4'h7);
      src[i] = 1'b0; step(2);
      look_stat("R4 fall", i, 4'h6);
      op(2'd2, 20'(BASE + i)); step(4);
      exp_none("R10 eoi idle"); look_stat("R10 eoi idle", i, 4'h4);
    end

    // message sources
    for (int i = 4; i < N; i++) begin
      src[i] = 1'b1; step(1); src[i] = 1'b0; step(4);
      exp_dlv("R6 msg pulse", i); exp_none("R6"); look_stat("R6 msg", i, 4'h0);
      op(2'd1, 20'(BASE + i)); step(4);
      exp_none("R8 reject msg"); look_stat("R8 reject msg", i, 4'h4);
      op(2'd3, '0); step(4);
      exp_dlv("R9 resend msg", i); exp_none("R9"); look_stat("R9 msg", i, 4'h0);
      op(2'd2, 20'(BASE + i)); step(4);
      exp_none("R10 eoi msg"); look_stat("R10 eoi msg", i, 4'h0);
      cfg(i, cur_srv[i], 8'hFF, 8'h00);
      src[i] = 1'b1; step(1); src[i] = 1'b0; step(4);
      exp_none("R6 masked msg"); look_stat("R6 masked pending", i, 4'h8);
      cur_prio[i] = cur_prio[i] + 8'd1;
      cfg(i, cur_srv[i], cur_prio[i], 8'h00); step(4);
      exp_dlv("R7 unmask msg", i); exp_none("R7"); look_stat("R7 msg cleared", i, 4'h0);
    end

    // R11 simultaneous messages drain lowest first
    src[7:4] = 4'hF; step(1); src[7:4] = 4'h0; step(8);
    for (int i = 4; i < N; i++) exp_dlv("R11 order", i);
    exp_none("R11");
    for (int i = 4; i < N; i++) op(2'd1, 20'(BASE + i));
    op(2'd3, '0); step(8);
    for (int i = 4; i < N; i++) exp_dlv("R9 R11 resend sweep", i);
    exp_none("R9 sweep");
    for (int i = 4; i < N; i++) look_stat("R9 sweep stat", i, 4'h0);

    // R7 level branch
    cfg(1, cur_srv[1], 8'hFF, 8'h00);
    src[1] = 1'b1; step(4);
    exp_none("R5 masked level"); look_stat("R5 masked level", 1, 4'h5);
    cfg(1, cur_srv[1], cur_prio[1], 8'h00); step(4);
    exp_dlv("R7 level unmask", 1); exp_none("R7 level"); look_stat("R7 level", 1, 4'h7);
    src[1] = 1'b0; step(2);
    op(2'd2, 20'(BASE + 1)); step(4);
    exp_none("R10 final eoi"); look_stat("R10 final", 1, 4'h4);

    // R2 presenter ops outside window
    op(2'd1, 20'(BASE + N));
    op(2'd1, 20'(BASE - 1));
    op(2'd2, 20'(BASE + N));
    step(4);
    exp_none("R2 outside ops");
    for (int i = 0; i < N; i++) look_stat("R2 outside ops stat", i, (i < 4) ? 4'h4 : 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule